// File: doc/BRIEF.md
# Rewindable Packet-Staging Transmit FIFO

This block stages bulk packets arriving from a host link before a downstream frame extractor reads them. Words are written in order at a working write pointer. A second pointer, the committed head, marks the end of the last packet that closed cleanly. When a packet's final beat arrives without an error, the head jumps to the working pointer and the whole packet becomes readable at once. When the final beat carries an error, the working pointer snaps back to the head, so every word of that packet disappears and the host can resend it. The read side only ever sees committed words. Packets are concatenated without any boundary marker, because one downstream frame may span several packets.

The write side has no back-pressure, since the upstream packet source cannot stall mid-packet. `full` is a plain status output. A beat offered while the store is full is dropped, a sticky overflow flag is raised, and the packet is discarded when its final beat arrives. The read side is a valid/ready stream. A word is transferred on each rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value. The default geometry is 2048 words of 32 bits, which is 8 KB.

Top module: `tx_stage_fifo`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `overflow` and `out_valid` are 0.
- R2: A good last beat (`in_valid`=1, `in_last`=1, `in_err`=0, not full, no overflow) commits the packet. `empty` reads 0 after that edge. The first word of the packet appears on `out_valid`/`out_data` after the following edge, provided the output stage was idle.
- R3: Words of a packet whose last beat has not yet arrived are never readable: `empty` stays 1 and `out_valid` stays 0 when nothing else is committed.
- R4: A last beat with `in_err`=1 discards every word of that packet. Nothing from it is ever read, and the next packet occupies the same space.
- R5: `full` is 1 exactly when the working pointer is DEPTH words ahead of the read pointer, counting uncommitted words.
- R6: A beat offered while full, or after an overflow in the same packet, is dropped and sets `overflow`. `overflow` stays 1 until that packet's last beat, which discards the packet and clears `overflow` on the same edge.
- R7: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` does not change.
- R8: Committed packets are read as one contiguous word stream, in commit order, with each word unchanged.
- R9: Cycles with `in_valid`=0 have no effect, whatever `in_data`, `in_last` and `in_err` carry.
- R10: Space freed by reads is reused, and data stays correct across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write beat present |
| in_data | input | DATA_W | Write word |
| in_last | input | 1 | Beat is the final one of its packet |
| in_err | input | 1 | Packet is bad; sampled on the last beat |
| out_valid | output | 1 | Read word available |
| out_ready | input | 1 | Consumer accepts the read word |
| out_data | output | DATA_W | Read word |
| full | output | 1 | Working pointer is DEPTH words ahead of read pointer |
| empty | output | 1 | No committed word left to fetch |
| overflow | output | 1 | Current packet lost a beat to a full store |

## Verification
If the head pointer is corrupted, committed data is either withheld or released early. That shows up as a missing or premature `out_valid` within two edges of a last beat, or as words from a rewound packet appearing on the read stream. If the working pointer is wrong after a rewind, the next packet is misplaced, and its first read word differs from what was sent. A bad full computation is visible the edge after the DEPTH-th beat, through `full` and `overflow`, and through data loss on readback after wrap-around.

// File: rtl/tx_stage_pkg.sv
package tx_stage_pkg;

  // Action taken by the write side on a given cycle
  typedef enum logic [2:0] {
    WA_IDLE   = 3'd0,
    WA_APPEND = 3'd1,
    WA_COMMIT = 3'd2,
    WA_REWIND = 3'd3,
    WA_DROP   = 3'd4
  } wr_act_e;

  function automatic logic act_writes(wr_act_e a);
    return (a == WA_APPEND) || (a == WA_COMMIT);
  endfunction

endpackage

// File: rtl/tx_stage_wr_ctrl.sv
module tx_stage_wr_ctrl
  import tx_stage_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  logic    in_last,
  input  logic    in_err,
  input  logic    full,
  output wr_act_e act,
  output logic    ovf_q
);

  logic doomed;
  assign doomed = full || ovf_q;

  always_comb begin
    act = WA_IDLE;
    if (in_valid) begin
      if (in_last) act = (in_err || doomed) ? WA_REWIND : WA_COMMIT;
      else         act = doomed ? WA_DROP : WA_APPEND;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      case (act)
        WA_DROP:               ovf_q <= 1'b1;
        WA_COMMIT, WA_REWIND:  ovf_q <= 1'b0;
        default:               ovf_q <= ovf_q;
      endcase
    end
  end

endmodule

// File: rtl/tx_stage_ptrs.sv
module tx_stage_ptrs
  import tx_stage_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wr_act_e       act,
  input  logic          pop,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          full,
  output logic          empty
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] ONE_P   = PW'(1);

  logic [PW-1:0] wr_ptr, hd_ptr, rd_ptr;
  logic [PW-1:0] wr_next;

  assign wr_next = wr_ptr + ONE_P;
  assign we      = act_writes(act);
  assign waddr   = wr_ptr[AW-1:0];
  assign raddr   = rd_ptr[AW-1:0];
  assign full    = (wr_ptr - rd_ptr) == DEPTH_P;
  assign empty   = (hd_ptr == rd_ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      hd_ptr <= '0;
    end else begin
      case (act)
        WA_APPEND: wr_ptr <= wr_next;
        WA_COMMIT: begin
          wr_ptr <= wr_next;
          hd_ptr <= wr_next;
        end
        WA_REWIND: wr_ptr <= hd_ptr;
        default:   wr_ptr <= wr_ptr;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rd_ptr <= '0;
    else if (pop) rd_ptr <= rd_ptr + ONE_P;
  end

endmodule

// File: rtl/tx_stage_mem.sv
module tx_stage_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/tx_stage_rd_port.sv
module tx_stage_rd_port (
  input  logic clk,
  input  logic rst_n,
  input  logic empty,
  input  logic out_ready,
  output logic pop,
  output logic out_valid
);

  assign pop = !empty && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (pop)       out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

endmodule

// File: rtl/tx_stage_fifo.sv
module tx_stage_fifo
  import tx_stage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              full,
  output logic              empty,
  output logic              overflow
);

  wr_act_e       act;
  logic          we, pop;
  logic [AW-1:0] waddr, raddr;

  tx_stage_wr_ctrl u_wr_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_err   (in_err),
    .full     (full),
    .act      (act),
    .ovf_q    (overflow)
  );

  tx_stage_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .pop   (pop),
    .we    (we),
    .waddr (waddr),
    .raddr (raddr),
    .full  (full),
    .empty (empty)
  );

  tx_stage_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (in_data),
    .re    (pop),
    .raddr (raddr),
    .rdata (out_data)
  );

  tx_stage_rd_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .empty     (empty),
    .out_ready (out_ready),
    .pop       (pop),
    .out_valid (out_valid)
  );

endmodule

// File: rtl/tx_stage_fifo_chk.sv
module tx_stage_fifo_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_err,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              full,
  input logic              empty,
  input logic              overflow
);

  assert_commit_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !in_err && !full && !overflow) |=> !empty);

  assert_valid_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !out_valid) |=> !out_valid);

  assert_err_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && in_err && empty) |=> empty);

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(in_valid && in_last)) |=> overflow);

  assert_ovf_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> !overflow);

  assert_ovf_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!overflow && !full) |=> !overflow);

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && empty && !out_valid) |=> (empty && $stable(overflow)));

endmodule

bind tx_stage_fifo tx_stage_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .in_err    (in_err),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .full      (full),
  .empty     (empty),
  .overflow  (overflow)
);

// File: tb/tx_stage_fifo_tb.sv
module tx_stage_fifo_tb;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_last = 1'b0;
  logic              in_err = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [DATA_W-1:0] out_data;
  logic              full, empty, overflow;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tx_stage_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk, .rst_n, .in_valid, .in_data, .in_last, .in_err,
    .out_valid, .out_ready, .out_data, .full, .empty, .overflow
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive a beat at the current negedge; returns at the negedge after it is captured
  task automatic push(input logic [31:0] d, input bit last, input bit err);
    in_valid = 1'b1; in_data = d; in_last = last; in_err = err;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
  endtask

  task automatic send_pkt(input int n, input logic [31:0] base, input bit err);
    for (int i = 0; i < n; i++) push(base + i, i == n - 1, err && (i == n - 1));
    idle();
  endtask

  task automatic drain(input int n, input logic [31:0] base, input string req);
    out_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      int t = 0;
      while (!out_valid && t < 20) begin @(negedge clk); t++; end
      chk(out_valid && out_data == base + i, req, out_data, base + i);
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0, "R1 full", full, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
  endtask

  task automatic t_commit();
    push(32'h100, 0, 0);
    chk(empty == 1'b1, "R3 uncommitted hidden", empty, 1);
    push(32'h101, 0, 0);
    chk(empty == 1'b1 && !out_valid, "R3 uncommitted hidden", empty, 1);
    push(32'h102, 1, 0);
    idle();
    chk(empty == 1'b0, "R2 empty after commit", empty, 0);
    chk(out_valid == 1'b0, "R2 valid not yet", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2 valid next edge", out_valid, 1);
    chk(out_data == 32'h100, "R2 first word", out_data, 32'h100);
    drain(3, 32'h100, "R2 data");
  endtask

  task automatic t_rewind();
    send_pkt(4, 32'hBAD0, 1);
    chk(empty == 1'b1, "R4 errored pkt hidden", empty, 1);
    chk(full == 1'b0, "R4 no full", full, 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R4 nothing read", out_valid, 0);
    send_pkt(2, 32'h200, 0);
    drain(2, 32'h200, "R4 resent pkt");
  endtask

  task automatic t_concat();
    send_pkt(2, 32'h400, 0);
    send_pkt(3, 32'h402, 0);
    drain(5, 32'h400, "R8 contiguous");
  endtask

  task automatic t_backpressure();
    send_pkt(3, 32'h300, 0);
    @(negedge clk);
    chk(out_valid && out_data == 32'h300, "R7 head word", out_data, 32'h300);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == 32'h300, "R7 hold", out_data, 32'h300);
    end
    drain(3, 32'h300, "R7 after hold");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) push(32'h500 + i, 0, 0);
    chk(full == 1'b1, "R5 full on working ptr", full, 1);
    chk(overflow == 1'b0, "R6 no overflow yet", overflow, 0);
    chk(empty == 1'b1, "R3 full but uncommitted", empty, 1);
    push(32'h5FF, 0, 0);
    chk(overflow == 1'b1, "R6 overflow set", overflow, 1);
    push(32'h5FE, 0, 0);
    chk(overflow == 1'b1, "R6 overflow sticky", overflow, 1);
    push(32'h5FD, 1, 0);
    idle();
    chk(overflow == 1'b0, "R6 overflow cleared", overflow, 0);
    chk(full == 1'b0, "R6 space released", full, 0);
    chk(empty == 1'b1, "R6 pkt discarded", empty, 1);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6 nothing read", out_valid, 0);
  endtask

  task automatic t_full_commit();
    send_pkt(DEPTH, 32'h600, 0);
    chk(full == 1'b1, "R5 full committed", full, 1);
    @(negedge clk);
    chk(full == 1'b0, "R5 full drops after fetch", full, 0);
    chk(out_valid == 1'b1, "R10 valid", out_valid, 1);
    drain(DEPTH, 32'h600, "R10 wrap data");
    send_pkt(5, 32'h700, 0);
    drain(5, 32'h700, "R10 reuse");
  endtask

  task automatic t_idle();
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b0; in_data = 32'hDEAD0000 + i; in_last = 1'b1; in_err = i[0];
      @(negedge clk);
      chk(empty == 1'b1 && !full && !out_valid && !overflow, "R9 idle no effect", {empty, full}, 2'b10);
    end
    idle();
    send_pkt(1, 32'h800, 0);
    drain(1, 32'h800, "R9 state intact");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_commit();
    t_rewind();
    t_concat();
    t_backpressure();
    t_overflow();
    t_full_commit();
    t_idle();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

endmodule